// File: doc/BRIEF.md
# Nested interrupt priority controller

This block decides which interrupt the processor core services next. It holds one two-bit software priority code for each maskable request line. It compares the requests against the current priority code that the core keeps in its condition code. A request is taken only when its programmed level is strictly above the running level. Among the requests that qualify, the highest level wins, and a tie goes to the line with the higher fixed vector.

When a request is taken, the block pulses a grant for one cycle. With the grant it gives the vector index and the vector address, raises a context-save strobe, and loads the current code with the granted line's code. A return-from-interrupt pops the previous code from an internal stack, so nested handlers unwind level by level.

A reset request and a software trap are never masked. The reset request empties the stack. The core writes priority codes through a byte-wide register port, and it can set the current code directly.

The level encoding is unusual and is used everywhere:

| Level | Meaning | Code |
|---|---|---|
| 0 | main program | 2'b10 |
| 1 | intermediate | 2'b01 |
| 2 | intermediate | 2'b00 |
| 3 | interrupts disabled | 2'b11 |

Top module: `nest_irq_ctrl`

## Requirements
- R1: After `rst_n` is released, `cc_bits` is 2'b11, `grant`, `save_ctx` and `stk_ovf` are low, every priority register reads 8'hFF, and the stack is empty.
- R2: Priority register r holds the code of line 4r+j in bits [2j+1:2j]. A write stores each field as written, except that code 2'b10 is stored as 2'b11. A write to an address at or above the register count is ignored. A read of such an address returns 8'h00. `reg_rdata` follows `reg_addr` without delay.
- R3: A maskable line is granted only in a cycle where `insn_end` is high and its stored level is strictly above the level of `cc_bits`. Otherwise it is not granted and stays pending for as long as its request is held.
- R4: Among the qualifying lines, the one with the highest level is chosen. On equal levels, the lowest line index is chosen, because line k owns vector index 13-k.
- R5: A decision made at a clock edge shows on the outputs after that edge. `grant` is high for that cycle, and `grant_vec` holds the vector index. `vec_addr` equals 16'hFFE0 plus twice the index. `save_ctx` is high for every grant except a reset grant. `cc_bits` takes the granted code, and the previous `cc_bits` is pushed.
- R6: `trap_req` with `insn_end` high is granted at any level, with vector index 14 (16'hFFFC). It loads `cc_bits` with 2'b11 and pushes the previous code. A trap wins over maskable lines.
- R7: `reset_req` is granted without any condition, with vector index 15 (16'hFFFE) and `save_ctx` low. It sets `cc_bits` to 2'b11, empties the stack, and takes precedence over every other input.
- R8: `iret` blocks any trap or maskable grant in its cycle. It restores `cc_bits` from the most recent pushed code. When the stack is empty, it leaves `cc_bits` unchanged.
- R9: A push while STACK_DEPTH codes are already held raises `stk_ovf` for that one cycle. The push is dropped, the stack contents are kept, and the grant and the new `cc_bits` still happen.
- R10: `cc_we` loads `cc_bits` from `cc_wdata` only in a cycle with no reset request, no `iret` and no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the block |
| irq_req | input | NUM_IRQ | Level-held maskable requests, line 0 has the highest fixed vector |
| reset_req | input | 1 | Non-maskable reset request |
| trap_req | input | 1 | Software trap request |
| insn_end | input | 1 | Core is at an instruction boundary |
| iret | input | 1 | Return from interrupt completes this cycle |
| cc_we | input | 1 | Core writes the current priority code |
| cc_wdata | input | 2 | Code written by `cc_we` |
| reg_we | input | 1 | Priority register write strobe |
| reg_addr | input | ADDR_W | Priority register address |
| reg_wdata | input | 8 | Priority register write data |
| reg_rdata | output | 8 | Priority register read data |
| grant | output | 1 | One-cycle grant pulse |
| grant_vec | output | 4 | Granted vector index |
| vec_addr | output | 16 | Granted vector address |
| save_ctx | output | 1 | Core must save its context |
| cc_bits | output | 2 | Current priority code |
| stk_ovf | output | 1 | Push dropped on a full stack |

## Verification
Directed sequences cover several cases. Simultaneous lines of equal level isolate the tie rule by line index. Held requests at a level equal to the running one show that a pending line is not taken. Back-to-back traps from main level fill the stack, trigger the overflow, and then unwind through every pop and one pop on an empty stack. The random phase mixes sparse request patterns, rare traps and reset requests, frequent code rewrites and gaps in `insn_end`. This separates masking by level from masking by instruction boundary, and grant precedence from `iret` and `cc_we` precedence.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int VEC_W = 4;

    localparam logic [1:0] CODE_L0 = 2'b10;
    localparam logic [1:0] CODE_L1 = 2'b01;
    localparam logic [1:0] CODE_L2 = 2'b00;
    localparam logic [1:0] CODE_L3 = 2'b11;

    localparam logic [VEC_W-1:0] VEC_RESET   = 4'd15;
    localparam logic [VEC_W-1:0] VEC_TRAP    = 4'd14;
    localparam logic [VEC_W-1:0] VEC_IRQ_TOP = 4'd13;

    localparam logic [15:0] VEC_BASE = 16'hFFE0;

    // Code to numeric level: 10->0, 01->1, 00->2, 11->3
    function automatic logic [1:0] level_of(input logic [1:0] code);
        return {code[1] ~^ code[0], code[0]};
    endfunction

    // Software may not program main level; it is promoted to disabled level
    function automatic logic [1:0] sanitize(input logic [1:0] code);
        return (code == CODE_L0) ? CODE_L3 : code;
    endfunction

endpackage

// File: rtl/nic_prio_regs.sv
module nic_prio_regs
    import nic_pkg::*;
#(
    parameter int NUM_IRQ  = 12,
    parameter int NUM_REGS = (NUM_IRQ + 3) / 4,
    parameter int ADDR_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    output logic [NUM_IRQ-1:0][1:0]  fields
);

    logic [NUM_REGS-1:0][7:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (addr == ADDR_W'(r)) begin
                    for (int j = 0; j < 4; j++) begin
                        regs_d[r][2*j +: 2] = sanitize(wdata[2*j +: 2]);
                    end
                end
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (addr == ADDR_W'(r)) begin
                rdata = regs_q[r];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_field
        assign fields[k] = regs_q[k / 4][2 * (k % 4) +: 2];
    end

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NUM_IRQ = 12,
    parameter int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0]       req,
    input  logic [NUM_IRQ-1:0][1:0]  fields,
    input  logic [1:0]               cur_code,
    output logic                     hit,
    output logic [IDX_W-1:0]         win_idx,
    output logic [1:0]               win_code
);

    logic [1:0] cur_lvl;
    logic [1:0] best_lvl;
    logic [1:0] cand_lvl;

    assign cur_lvl = level_of(cur_code);

    // Scan from the lowest fixed vector upward; >= lets lower indices
    // override on equal level, so ties resolve to the higher vector.
    always_comb begin
        hit      = 1'b0;
        win_idx  = '0;
        win_code = CODE_L3;
        best_lvl = 2'd0;
        cand_lvl = 2'd0;
        for (int k = NUM_IRQ - 1; k >= 0; k--) begin
            cand_lvl = level_of(fields[k]);
            if (req[k] && (cand_lvl > cur_lvl) && (!hit || cand_lvl >= best_lvl)) begin
                hit      = 1'b1;
                best_lvl = cand_lvl;
                win_idx  = IDX_W'(k);
                win_code = fields[k];
            end
        end
    end

endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack
    import nic_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       push,
    input  logic       pop,
    input  logic [1:0] push_data,
    output logic [1:0] pop_data,
    output logic       empty,
    output logic       overflow
);

    typedef struct packed {
        logic [DEPTH-1:0][1:0] ent;
        logic [PTR_W-1:0]      cnt;
        logic                  ovf;
    } stk_t;

    stk_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ovf = 1'b0;
        if (clear) begin
            s_d.cnt = '0;
        end else if (push) begin
            if (s_q.cnt == PTR_W'(DEPTH)) begin
                s_d.ovf = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (s_q.cnt == PTR_W'(i)) begin
                        s_d.ent[i] = push_data;
                    end
                end
                s_d.cnt = s_q.cnt + PTR_W'(1);
            end
        end else if (pop && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - PTR_W'(1);
        end
    end

    always_comb begin
        pop_data = CODE_L3;
        for (int i = 0; i < DEPTH; i++) begin
            if (s_q.cnt == PTR_W'(i + 1)) begin
                pop_data = s_q.ent[i];
            end
        end
    end

    assign empty    = (s_q.cnt == '0);
    assign overflow = s_q.ovf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ent <= '1;
            s_q.cnt <= '0;
            s_q.ovf <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_IRQ     = 12,
    parameter int STACK_DEPTH = 5,
    localparam int NUM_REGS   = (NUM_IRQ + 3) / 4,
    localparam int ADDR_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               reset_req,
    input  logic               trap_req,
    input  logic               insn_end,
    input  logic               iret,
    input  logic               cc_we,
    input  logic [1:0]         cc_wdata,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               grant,
    output logic [3:0]         grant_vec,
    output logic [15:0]        vec_addr,
    output logic               save_ctx,
    output logic [1:0]         cc_bits,
    output logic               stk_ovf
);

    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    typedef struct packed {
        logic [1:0]       cc;
        logic             grant;
        logic [VEC_W-1:0] vec;
        logic             save;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [NUM_IRQ-1:0][1:0] fields;
    logic                    arb_hit;
    logic [IDX_W-1:0]        arb_idx;
    logic [1:0]              arb_code;
    logic                    stk_clear, stk_push, stk_pop, stk_empty;
    logic [1:0]              stk_top;

    nic_prio_regs #(
        .NUM_IRQ (NUM_IRQ),
        .NUM_REGS(NUM_REGS),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .fields(fields)
    );

    nic_arbiter #(
        .NUM_IRQ(NUM_IRQ),
        .IDX_W  (IDX_W)
    ) u_arb (
        .req     (irq_req),
        .fields  (fields),
        .cur_code(c_q.cc),
        .hit     (arb_hit),
        .win_idx (arb_idx),
        .win_code(arb_code)
    );

    nic_level_stack #(
        .DEPTH(STACK_DEPTH)
    ) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (stk_clear),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_data(c_q.cc),
        .pop_data (stk_top),
        .empty    (stk_empty),
        .overflow (stk_ovf)
    );

    // Precedence: reset request, iret, trap, maskable line, direct code write
    always_comb begin
        c_d       = c_q;
        c_d.grant = 1'b0;
        c_d.save  = 1'b0;
        stk_clear = 1'b0;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        if (reset_req) begin
            c_d.grant = 1'b1;
            c_d.vec   = VEC_RESET;
            c_d.cc    = CODE_L3;
            stk_clear = 1'b1;
        end else if (iret) begin
            if (!stk_empty) begin
                stk_pop = 1'b1;
                c_d.cc  = stk_top;
            end
        end else if (insn_end && trap_req) begin
            c_d.grant = 1'b1;
            c_d.save  = 1'b1;
            c_d.vec   = VEC_TRAP;
            c_d.cc    = CODE_L3;
            stk_push  = 1'b1;
        end else if (insn_end && arb_hit) begin
            c_d.grant = 1'b1;
            c_d.save  = 1'b1;
            c_d.vec   = VEC_IRQ_TOP - VEC_W'(arb_idx);
            c_d.cc    = arb_code;
            stk_push  = 1'b1;
        end else if (cc_we) begin
            c_d.cc = cc_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.cc    <= CODE_L3;
            c_q.grant <= 1'b0;
            c_q.vec   <= '0;
            c_q.save  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign grant     = c_q.grant;
    assign grant_vec = c_q.vec;
    assign vec_addr  = VEC_BASE + {11'd0, c_q.vec, 1'b0};
    assign save_ctx  = c_q.save;
    assign cc_bits   = c_q.cc;

endmodule

// File: rtl/nic_checker.sv
module nic_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reset_req,
    input logic        trap_req,
    input logic        insn_end,
    input logic        iret,
    input logic        grant,
    input logic [3:0]  grant_vec,
    input logic [15:0] vec_addr,
    input logic        save_ctx,
    input logic [1:0]  cc_bits,
    input logic        stk_ovf
);

    AST_MASKABLE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && grant_vec < 4'd14) |-> $past(insn_end)); // R3

    AST_VEC_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (vec_addr == 16'hFFE0 + {11'd0, grant_vec, 1'b0})); // R5

    AST_SAVE_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        save_ctx |-> (grant && grant_vec != 4'd15)); // R5

    AST_TRAP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && insn_end && !reset_req && !iret) |=>
        (grant && grant_vec == 4'd14 && cc_bits == 2'b11)); // R6

    AST_RESET_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (grant && grant_vec == 4'd15 && cc_bits == 2'b11 && !save_ctx)); // R7

    AST_IRET_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (iret && !reset_req) |=> !grant); // R8

    AST_NO_OVERFLOW_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf |-> (grant && save_ctx)); // R9

endmodule

bind nest_irq_ctrl nic_checker u_nic_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .reset_req(reset_req),
    .trap_req (trap_req),
    .insn_end (insn_end),
    .iret     (iret),
    .grant    (grant),
    .grant_vec(grant_vec),
    .vec_addr (vec_addr),
    .save_ctx (save_ctx),
    .cc_bits  (cc_bits),
    .stk_ovf  (stk_ovf)
);

// File: tb/nest_irq_ctrl_test.sv
`timescale 1ns/1ps
module nest_irq_ctrl_test;

    localparam int NI = 12;
    localparam int SD = 5;
    localparam int NR = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] irq_req = '0;
    logic          reset_req = 1'b0, trap_req = 1'b0, insn_end = 1'b0, iret = 1'b0;
    logic          cc_we = 1'b0;
    logic [1:0]    cc_wdata = 2'b00;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [7:0]    reg_wdata = 8'h00;
    logic [7:0]    reg_rdata;
    logic          grant, save_ctx, stk_ovf;
    logic [3:0]    grant_vec;
    logic [15:0]   vec_addr;
    logic [1:0]    cc_bits;

    int checks = 0;
    int errors = 0;

    // model state
    logic [1:0] m_fld [NI];
    logic [1:0] m_cc;
    logic [1:0] m_stk [SD];
    int         m_cnt;
    bit         e_grant, e_save, e_ovf;
    int         e_vec;

    always #2 clk = ~clk;

    nest_irq_ctrl #(.NUM_IRQ(NI), .STACK_DEPTH(SD)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reset_req(reset_req),
        .trap_req(trap_req), .insn_end(insn_end), .iret(iret), .cc_we(cc_we),
        .cc_wdata(cc_wdata), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grant(grant),
        .grant_vec(grant_vec), .vec_addr(vec_addr), .save_ctx(save_ctx),
        .cc_bits(cc_bits), .stk_ovf(stk_ovf)
    );

    function automatic int lvl(input logic [1:0] c);
        case (c)
            2'b10:   return 0;
            2'b01:   return 1;
            2'b00:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [1:0] a);
        logic [7:0] v = 8'h00;
        if (int'(a) < NR)
            for (int j = 0; j < 4; j++) v[2*j +: 2] = m_fld[4*int'(a) + j];
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push_model();
        if (m_cnt == SD) e_ovf = 1'b1;
        else begin
            m_stk[m_cnt] = m_cc;
            m_cnt++;
        end
    endtask

    task automatic model_step();
        int best = -1;
        int bl = -1;
        e_grant = 0; e_save = 0; e_ovf = 0;
        for (int k = 0; k < NI; k++)
            if (irq_req[k] && lvl(m_fld[k]) > lvl(m_cc) && lvl(m_fld[k]) > bl) begin
                best = k;
                bl = lvl(m_fld[k]);
            end
        if (reset_req) begin
            e_grant = 1; e_vec = 15; m_cc = 2'b11; m_cnt = 0;
        end else if (iret) begin
            if (m_cnt > 0) begin
                m_cnt--;
                m_cc = m_stk[m_cnt];
            end
        end else if (insn_end && trap_req) begin
            e_grant = 1; e_save = 1; e_vec = 14;
            push_model();
            m_cc = 2'b11;
        end else if (insn_end && best >= 0) begin
            e_grant = 1; e_save = 1; e_vec = 13 - best;
            push_model();
            m_cc = m_fld[best];
        end else if (cc_we) begin
            m_cc = cc_wdata;
        end
        if (reg_we && int'(reg_addr) < NR)
            for (int j = 0; j < 4; j++) begin
                m_fld[4*int'(reg_addr) + j] =
                    (reg_wdata[2*j +: 2] == 2'b10) ? 2'b11 : reg_wdata[2*j +: 2];
            end
    endtask

    // inputs are set at a falling edge; outputs compared at the next one
    task automatic cycle(input string tag);
        model_step();
        @(negedge clk);
        chk(grant == e_grant, (tag == "") ? "R3" : tag, "grant", grant, e_grant);
        if (e_grant) begin
            chk(int'(grant_vec) == e_vec, (tag == "") ? "R4" : tag, "grant_vec", grant_vec, e_vec);
            chk(vec_addr == 16'hFFE0 + 16'(2 * e_vec), (tag == "") ? "R5" : tag,
                "vec_addr", vec_addr, 16'hFFE0 + 16'(2 * e_vec));
        end
        chk(save_ctx == e_save, (tag == "") ? "R5" : tag, "save_ctx", save_ctx, e_save);
        chk(cc_bits == m_cc, (tag == "") ? "R5" : tag, "cc_bits", cc_bits, m_cc);
        chk(stk_ovf == e_ovf, (tag == "") ? "R9" : tag, "stk_ovf", stk_ovf, e_ovf);
        chk(reg_rdata == exp_rdata(reg_addr), (tag == "") ? "R2" : tag, "reg_rdata",
            reg_rdata, exp_rdata(reg_addr));
    endtask

    task automatic idle();
        irq_req = '0; reset_req = 0; trap_req = 0; insn_end = 0; iret = 0;
        cc_we = 0; reg_we = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < NI; k++) m_fld[k] = 2'b11;
        for (int i = 0; i < SD; i++) m_stk[i] = 2'b11;
        m_cc = 2'b11; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(cc_bits == 2'b11, "R1", "cc_bits", cc_bits, 2'b11);
        chk(!grant && !save_ctx && !stk_ovf, "R1", "grant/save/ovf",
            {grant, save_ctx, stk_ovf}, 0);
        for (int a = 0; a < NR; a++) begin
            reg_addr = 2'(a);
            #0.5;
            chk(reg_rdata == 8'hFF, "R1", "reg_rdata", reg_rdata, 8'hFF);
        end
        iret = 1; cycle("R1");  // empty stack: code stays 11
        idle();

        // R2 field storage and main-level promotion
        reg_we = 1; reg_addr = 2'd0; reg_wdata = 8'b10_01_00_10;
        cycle("R2");
        reg_we = 0;
        cycle("R2");
        chk(reg_rdata == 8'b11_01_00_11, "R2", "promoted fields", reg_rdata, 8'b11_01_00_11);
        reg_we = 1; reg_addr = 2'd3; reg_wdata = 8'h55;
        cycle("R2");
        reg_we = 0;
        cycle("R2");
        reg_we = 1; reg_addr = 2'd1; reg_wdata = 8'h00;
        cycle("R2");
        idle();

        // R10 direct write, then R4 tie among level-2 lines 1, 5, 7
        cc_we = 1; cc_wdata = 2'b10;
        cycle("R10");
        idle();
        irq_req[1] = 1; irq_req[5] = 1; irq_req[7] = 1;
        cycle("R3");           // no instruction boundary: nothing taken
        insn_end = 1;
        cycle("R4");
        chk(grant_vec == 4'd12, "R4", "tie winner", grant_vec, 4'd12);
        cycle("R3");           // equal level now: stays pending
        insn_end = 0; iret = 1;
        cycle("R8");
        chk(cc_bits == 2'b10, "R8", "restored code", cc_bits, 2'b10);
        iret = 0; insn_end = 1; irq_req[0] = 1;  // level 3 line beats level 2
        cycle("R4");
        chk(grant_vec == 4'd13, "R4", "higher level", grant_vec, 4'd13);
        idle();
        iret = 1; cycle("R8");
        idle();

        // R6/R9 traps from main level until overflow, then unwind
        insn_end = 1; trap_req = 1;
        for (int t = 0; t < SD + 1; t++) cycle((t == SD) ? "R9" : "R6");
        chk(stk_ovf == 1'b1, "R9", "overflow flag", stk_ovf, 1);
        idle();
        iret = 1;
        for (int t = 0; t < SD + 1; t++) cycle("R8");
        chk(cc_bits == 2'b10, "R8", "unwound code", cc_bits, 2'b10);
        idle();

        // R7 reset request over a trap
        reset_req = 1; trap_req = 1; insn_end = 1;
        cycle("R7");
        idle();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            idle();
            for (int k = 0; k < NI; k++) irq_req[k] = ($urandom_range(0, 9) == 0);
            insn_end  = ($urandom_range(0, 9) < 7);
            iret      = ($urandom_range(0, 9) == 0);
            trap_req  = ($urandom_range(0, 29) == 0);
            reset_req = ($urandom_range(0, 199) == 0);
            cc_we     = ($urandom_range(0, 5) == 0);
            cc_wdata  = 2'($urandom_range(0, 3));
            reg_we    = ($urandom_range(0, 9) == 0);
            reg_addr  = 2'($urandom_range(0, 3));
            reg_wdata = 8'($urandom_range(0, 255));
            cycle("");
        end
        idle();
        cycle("");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule